// File: doc/BRIEF.md
# TDM Audio Clock Generator

This block turns one audio reference clock into the three clocks of a multi-slot serial audio frame: a master clock, a bit clock and a frame sync. It also drives a slot and bit position bus that serializers can follow. It runs as the clock controller, so it drives the clocks even when no serializer is attached.

The master clock divider and the bit clock divider are each programmed as the division factor minus one. The frame shape comes from two encoded fields. One field is the slot count minus one. The other is a two-bit slot width code. The bit clock rate must therefore equal the sample rate times the number of slots times the bits per slot. For example, six 32-bit slots at 48 kHz need 9.216 MHz, which is half of an 18.432 MHz reference. That frame is 384 reference cycles long.

When the enable input rises, the block captures the configuration and starts a frame. When the enable input is released, the block completes the frame in progress and then goes quiet.

Top module: `tdm_clk_unit`

## Requirements
- R1: While reset is asserted and after it is released with enable low, `mck_o`, `sck_o` and `fs_o` are 0 and both position outputs are 0.
- R2: With bit clock field value D, one bit clock period is N = D+1 reference cycles. Counting from the start of each period, `sck_o` is low for floor(N/2) reference cycles and then high. D = 0 passes the reference clock straight through to `sck_o` while the block runs.
- R3: With master clock field value E, `mck_o` has a period of M = E+1 reference cycles. It is low for floor(M/2) reference cycles and then high. E = 0 passes the reference clock through while the block runs.
- R4: The slot width code selects the bits per slot: 0 selects 8, 1 selects 16, 2 selects 24 and 3 selects 32. `bit_idx_o` counts 0 up to width-1, advancing once per bit clock period.
- R5: The slot count field holds slots-1 (field value 5 gives 6 slots). `slot_idx_o` advances when `bit_idx_o` wraps and returns to 0 after the last slot.
- R6: `fs_o` is high exactly while `slot_idx_o` is 0. The frame period is N × bits × slots reference cycles.
- R7: The position outputs and `fs_o` change only on the reference edge where `sck_o` starts its low phase.
- R8: Raising `en_i` while idle starts a frame at the next reference edge. That frame begins with `sck_o` low, `fs_o` high and both positions at 0.
- R9: After `en_i` goes low, the block runs to the end of the current frame. The frame ends after the last bit of the last slot. All outputs are then 0, and this holds even when `en_i` drops in the first cycle of a frame.
- R10: The configuration is captured only when a frame sequence starts. Changes to the configuration inputs while the block runs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Audio reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Run request |
| mck_div_i | input | 8 | Master clock factor minus one |
| sck_div_i | input | 8 | Bit clock factor minus one |
| slots_m1_i | input | 3 | Slots per frame minus one |
| slot_size_i | input | 2 | Slot width code |
| mck_o | output | 1 | Master clock output |
| sck_o | output | 1 | Bit clock output |
| fs_o | output | 1 | Frame sync, high during slot 0 |
| slot_idx_o | output | 3 | Current slot number |
| bit_idx_o | output | 5 | Current bit within slot |

## Verification
Two events can fall on the same reference edge: the frame-end wrap of the counters, and the stop decision driven by a released enable. Both happen at once when the enable is dropped so that it is sampled exactly on the last bit of a frame. This is done in the 384-cycle six-slot case. The opposite extreme drops the enable in the first cycle of a long odd-divider frame. In both cases a scoreboard predicts every reference cycle, and it expects the clocks to run to the frame boundary and then go all-zero on the following cycle. A configuration change made mid-run is checked in the same way: the outputs are compared against the captured settings.

// File: rtl/tdm_clk_pkg.sv
package tdm_clk_pkg;
  localparam int DIV_W   = 8;
  localparam int SLOTF_W = 3;
  localparam int SIZEF_W = 2;
  localparam int BIT_W   = SIZEF_W + 3;

  typedef struct packed {
    logic [DIV_W-1:0]   mck_m1;
    logic [DIV_W-1:0]   sck_m1;
    logic [SLOTF_W-1:0] slots_m1;
    logic [SIZEF_W-1:0] size_code;
  } cfg_t;

  // width code c selects (c+1)*8 bits; last bit index is c*8+7
  function automatic logic [BIT_W-1:0] last_bit_of(input logic [SIZEF_W-1:0] code);
    return {code, 3'b111};
  endfunction
endpackage

// File: rtl/tdm_clk_div.sv
module tdm_clk_div #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] fm1,
  output logic         lvl_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_nxt;

  // number of low phases = floor((fm1+1)/2)
  function automatic logic [W-1:0] low_phases(input logic [W-1:0] m1);
    logic [W:0] f;
    f = {1'b0, m1} + 1'b1;
    return f[W:1];
  endfunction

  assign wrap_o  = run && (cnt_q == fm1);
  assign cnt_nxt = (cnt_q == fm1) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      lvl_o <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      lvl_o <= (cnt_nxt >= low_phases(fm1));
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= fm1));
  assert_low_after_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && fm1 != '0) |=> !lvl_o);
endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr #(
  parameter int SW = 3,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          tick,
  input  logic [BW-1:0] bits_m1,
  input  logic [SW-1:0] slots_m1,
  output logic [BW-1:0] bit_o,
  output logic [SW-1:0] slot_o,
  output logic          last_o
);
  logic last_bit, last_slot;

  assign last_bit  = (bit_o == bits_m1);
  assign last_slot = (slot_o == slots_m1);
  assign last_o    = tick && last_bit && last_slot;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      bit_o  <= '0;
      slot_o <= '0;
    end else if (tick) begin
      if (last_bit) begin
        bit_o  <= '0;
        slot_o <= last_slot ? '0 : slot_o + 1'b1;
      end else begin
        bit_o <= bit_o + 1'b1;
      end
    end
  end

  assert_bit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (bit_o <= bits_m1));
  assert_slot_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (slot_o <= slots_m1));
endmodule

// File: rtl/tdm_clk_unit.sv
module tdm_clk_unit
  import tdm_clk_pkg::*;
(
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [DIV_W-1:0]   mck_div_i,
  input  logic [DIV_W-1:0]   sck_div_i,
  input  logic [SLOTF_W-1:0] slots_m1_i,
  input  logic [SIZEF_W-1:0] slot_size_i,
  output logic               mck_o,
  output logic               sck_o,
  output logic               fs_o,
  output logic [SLOTF_W-1:0] slot_idx_o,
  output logic [BIT_W-1:0]   bit_idx_o
);
  cfg_t cfg_q;
  logic active_q, start, stop_req;
  logic sck_lvl, sck_wrap, mck_lvl, mck_wrap, frame_last;

  assign start    = en_i && !active_q;
  assign stop_req = active_q && frame_last && !en_i;

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cfg_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cfg_q    <= '{mck_m1: mck_div_i, sck_m1: sck_div_i,
                    slots_m1: slots_m1_i, size_code: slot_size_i};
    end else if (stop_req) begin
      active_q <= 1'b0;
    end
  end

  tdm_clk_div #(.W(DIV_W)) u_sck_div (
    .clk(clk_ref), .rst_n(rst_n), .run(active_q), .fm1(cfg_q.sck_m1),
    .lvl_o(sck_lvl), .wrap_o(sck_wrap));

  tdm_clk_div #(.W(DIV_W)) u_mck_div (
    .clk(clk_ref), .rst_n(rst_n), .run(active_q), .fm1(cfg_q.mck_m1),
    .lvl_o(mck_lvl), .wrap_o(mck_wrap));

  tdm_frame_ctr #(.SW(SLOTF_W), .BW(BIT_W)) u_frame (
    .clk(clk_ref), .rst_n(rst_n), .active(active_q), .tick(sck_wrap),
    .bits_m1(last_bit_of(cfg_q.size_code)), .slots_m1(cfg_q.slots_m1),
    .bit_o(bit_idx_o), .slot_o(slot_idx_o), .last_o(frame_last));

  // a factor of one hands the reference clock through
  assign sck_o = active_q && ((cfg_q.sck_m1 == '0) ? clk_ref : sck_lvl);
  assign mck_o = active_q && ((cfg_q.mck_m1 == '0) ? clk_ref : mck_lvl);
  assign fs_o  = active_q && (slot_idx_o == '0);

  assert_pos_on_fall_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (active_q && $past(active_q) && (bit_idx_o != $past(bit_idx_o))) |-> $past(sck_wrap));
  assert_stop_at_end_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(active_q) |-> $past(frame_last && !en_i));
  assert_cfg_hold_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (active_q && $past(active_q)) |-> $stable(cfg_q));
  assert_mck_high_at_wrap_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mck_wrap && cfg_q.mck_m1 != '0) |-> mck_lvl);
endmodule

// File: tb/tb_tdm_clk_unit.sv
module tb_tdm_clk_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [7:0] mck_div = '0, sck_div = '0;
  logic [2:0] slots_m1 = '0;
  logic [1:0] size = '0;
  logic mck, sck, fs;
  logic [2:0] slot_idx;
  logic [4:0] bit_idx;

  int checks = 0, errors = 0, cyc = 0;

  typedef struct {
    int    cyc;
    int    mck, sck, fs, slot, bitn;
    string note;
  } item_t;
  item_t q[$];

  tdm_clk_unit dut (
    .clk_ref(clk), .rst_n(rst_n), .en_i(en), .mck_div_i(mck_div),
    .sck_div_i(sck_div), .slots_m1_i(slots_m1), .slot_size_i(size),
    .mck_o(mck), .sck_o(sck), .fs_o(fs), .slot_idx_o(slot_idx), .bit_idx_o(bit_idx));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at cyc %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  // monitor: compare at the falling reference edge
  always @(negedge clk) begin
    while (q.size() != 0 && q[0].cyc == cyc) begin
      item_t it;
      it = q.pop_front();
      chk({"R3 ", it.note}, "mck", int'(mck), it.mck);
      chk({"R2 ", it.note}, "sck", int'(sck), it.sck);
      chk({"R6 ", it.note}, "fs", int'(fs), it.fs);
      chk({"R5 ", it.note}, "slot", int'(slot_idx), it.slot);
      chk({"R4 R7 ", it.note}, "bit", int'(bit_idx), it.bitn);
    end
  end

  function automatic int clk_lvl(int k, int n);
    return (n == 1) ? 0 : (((k % n) >= (n / 2)) ? 1 : 0);
  endfunction

  // driver: enable, predict every cycle, drop enable after d cycles
  task automatic run_case(int m1, int s1, int sl, int sz, int d, bit chg);
    int n, m, w, s, f, t, c;
    @(negedge clk);
    mck_div = 8'(m1); sck_div = 8'(s1); slots_m1 = 3'(sl); size = 2'(sz);
    en = 1'b1;
    c = cyc;
    n = s1 + 1; m = m1 + 1; w = (sz + 1) * 8; s = sl + 1;
    f = n * w * s;
    t = ((d + f - 1) / f) * f;
    for (int k = 0; k < t; k++) begin
      item_t it;
      it.cyc  = c + 1 + k;
      it.mck  = clk_lvl(k, m);
      it.sck  = clk_lvl(k, n);
      it.bitn = (k / n) % w;
      it.slot = (k / (n * w)) % s;
      it.fs   = (it.slot == 0) ? 1 : 0;
      it.note = (k == 0) ? "R8 start" : (chg ? "R10 cfg held" : "run");
      q.push_back(it);
    end
    for (int k = 0; k < 6; k++) begin
      item_t it;
      it = '{cyc: c + 1 + t + k, mck: 0, sck: 0, fs: 0, slot: 0, bitn: 0,
             note: "R9 stopped"};
      q.push_back(it);
    end
    if (chg) begin
      repeat (3) @(negedge clk);
      mck_div = 8'd3; sck_div = 8'd4; slots_m1 = 3'd0; size = 2'd0;
      repeat (d - 3) @(negedge clk);
    end else begin
      repeat (d) @(negedge clk);
    end
    en = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "mck in reset", int'(mck), 0);
    chk("R1", "sck in reset", int'(sck), 0);
    chk("R1", "fs in reset", int'(fs), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "sck idle", int'(sck), 0);
    chk("R1", "fs idle", int'(fs), 0);
    chk("R1", "pos idle", int'({slot_idx, bit_idx}), 0);
    // 2 slots of 8 bits, sck /2, mck /3, drop mid second frame
    run_case(2, 1, 1, 0, 40, 1'b0);
    // 6 slots of 32 bits, sck /2, mck passthrough, stop sampled on last bit, cfg poked
    run_case(0, 1, 5, 3, 384, 1'b1);
    // sck passthrough, mck /4, single 16-bit slot
    run_case(3, 0, 0, 1, 20, 1'b0);
    // odd sck /5, mck /2, 3 slots of 24 bits, enable dropped in first cycle
    run_case(1, 4, 2, 2, 1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule